// File: doc/BRIEF.md
# Error-Correcting Pulsed Latch Register

This block is a stage register of N protected bits for a pipeline built from pulsed latches. It is modelled on a fast base clock: a one-cycle capture strobe stands in for the main latch pulse, and an internally delayed check strobe follows it by a fixed number of base cycles. Each bit keeps the value caught at the capture strobe. At the check strobe it compares that value against its live input and stores the result as a one-bit error flag. The bit's output is the captured value XORed with its flag. A bit whose data arrived after the capture strobe is therefore turned to its correct value without the upstream logic computing it again.

The flags of all bits are ORed into one register error output, which a recovery controller can watch. When the flags are cleared depends on the stage that follows. For a shallow following stage, the next capture strobe clears them. For a deep following stage, the controller clears them with an explicit clear input after it has given the following stage its extra cycle.

Top module: `eclr_register`

## Requirements
- R1: A cycle with `rst_n` low at a clock edge sets `q` to all zeros and `err_reg` to 0 from that edge on.
- R2: At an edge where `cap_stb` is 1, every bit captures `d`. If `d` does not change before the check, `q` equals the captured value and `err_reg` stays 0.
- R3: The check takes place at the edge CHECK_DELAY base cycles after the capture edge. If `d` differs from the captured bit at that edge, the bit's flag is set and its `q` is the inverse of the captured bit. At the edge before the check, `q` still shows the captured value.
- R4: Flags are set bit by bit, so several bits are corrected at the same check. Bits whose input did not change keep their flag at 0 and their `q` equal to the captured value.
- R5: `err_reg` is 1 exactly when at least one bit flag is set, and it changes at the same edge as the flags.
- R6: With `mode_deep` = 0 (shallow), a `cap_stb` edge while `err_reg` is 1 clears all flags at that edge. In this mode `clear_err` has no effect.
- R7: With `mode_deep` = 1 (deep), `cap_stb` does not clear the flags. `clear_err` high at an edge clears all flags at that edge.
- R8: If the check and a clear fall on the same edge, the check result is loaded. The clear does not win.
- R9: With no capture, no check and no active clear at an edge, `q` and `err_reg` hold their values, whatever `d` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_stb | input | 1 | One-cycle main capture strobe |
| mode_deep | input | 1 | 0: following stage shallow, clear on next capture; 1: deep, clear on `clear_err` |
| clear_err | input | 1 | Flag clear from the recovery controller, used in deep mode only |
| d | input | N | Live data from the preceding logic stage |
| q | output | N | Corrected register output |
| err_reg | output | 1 | OR of all bit error flags |

## Verification
Two functions can fall on the same edge: the delayed check loading a fresh mismatch, and a clear of the flags. The bench provokes this in deep mode. With a flag already set from an earlier error, it captures a wrong word, moves `d` to the correct word, and raises `clear_err` so that it is sampled at the check edge. Afterwards, `q` must equal the correct word with a new error pattern, and `err_reg` must still be 1. Both outputs are compared against values the bench computes from R8.

// File: rtl/eclr_pkg.sv
// Package: shared types for the error-correcting pulsed latch register.
// Assumes nothing beyond standard SystemVerilog enums.
package eclr_pkg;

    // Selects how stored error flags are released.
    typedef enum logic {
        CLR_ON_CAPTURE = 1'b0,  // shallow following stage
        CLR_ON_COMMAND = 1'b1   // deep following stage
    } clr_mode_e;

endpackage

// File: rtl/eclr_strobe_delay.sv
// Module: eclr_strobe_delay
// Produces the delayed check strobe from the capture strobe by shifting it
// through DLY registers, so the check acts DLY edges after the capture.
// Assumes DLY >= 1 and capture strobes one base cycle wide.
module eclr_strobe_delay #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_stb,
    output logic chk_stb
);

    generate
        if (DLY == 1) begin : g_single
            logic stage_q;

            // Single-stage delay register.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= cap_stb;
            end

            assign chk_stb = stage_q;
        end else begin : g_chain
            logic [DLY-1:0] chain_q;

            // Shift register carrying the capture strobe forward.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[DLY-2:0], cap_stb};
            end

            assign chk_stb = chain_q[DLY-1];
        end
    endgenerate

endmodule

// File: rtl/eclr_bit_cell.sv
// Module: eclr_bit_cell
// One protected bit: a main latch loaded at the capture strobe and a one-bit
// correction latch loaded with the input/main mismatch at the check strobe.
// The output is the main value XOR the flag. A check on the same edge as a
// clear takes precedence. Assumes synchronous strobes on the base clock.
module eclr_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_stb,
    input  logic chk_stb,
    input  logic clr_flag,
    input  logic d_bit,
    output logic main_bit,
    output logic flag_bit,
    output logic q_bit
);

    logic mismatch;

    // Comparator between live input and captured value.
    always_comb mismatch = d_bit ^ main_bit;

    // Main latch: takes the input only at the capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       main_bit <= 1'b0;
        else if (cap_stb) main_bit <= d_bit;
    end

    // Correction latch: loads mismatch at check, otherwise honours clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_bit <= 1'b0;
        else if (chk_stb)  flag_bit <= mismatch;
        else if (clr_flag) flag_bit <= 1'b0;
    end

    // Corrected output.
    always_comb q_bit = main_bit ^ flag_bit;

endmodule

// File: rtl/eclr_clear_ctl.sv
// Module: eclr_clear_ctl
// Decides when the correction flags are released: on a capture strobe while
// the register reports an error (shallow mode) or on the external clear
// (deep mode). Assumes the mode input is stable around strobes.
module eclr_clear_ctl
    import eclr_pkg::*;
(
    input  clr_mode_e mode,
    input  logic      cap_stb,
    input  logic      err_any,
    input  logic      clear_err,
    output logic      clr_flags
);

    // Mode-dependent clear selection.
    always_comb begin
        unique case (mode)
            CLR_ON_CAPTURE: clr_flags = cap_stb & err_any;
            CLR_ON_COMMAND: clr_flags = clear_err;
            default:        clr_flags = 1'b0;
        endcase
    end

endmodule

// File: rtl/eclr_register.sv
// Module: eclr_register (top)
// N-bit error-correcting pulsed latch register modelled on a base clock.
// The capture strobe loads all main latches. A check strobe CHECK_DELAY
// cycles later records per-bit late arrivals, which invert the affected
// outputs. The flags are ORed into err_reg and released according to
// mode_deep. Assumes capture strobes are one cycle wide.
module eclr_register
    import eclr_pkg::*;
#(
    parameter int N           = 8,
    parameter int CHECK_DELAY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_stb,
    input  logic         mode_deep,
    input  logic         clear_err,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic         err_reg
);

    logic         chk_stb;
    logic         clr_flags;
    logic [N-1:0] f_vec;
    logic [N-1:0] flag_vec;
    clr_mode_e    mode;

    // Mode decode from the plain port.
    always_comb mode = mode_deep ? CLR_ON_COMMAND : CLR_ON_CAPTURE;

    eclr_strobe_delay #(.DLY(CHECK_DELAY)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_stb (cap_stb),
        .chk_stb (chk_stb)
    );

    eclr_clear_ctl u_clr (
        .mode      (mode),
        .cap_stb   (cap_stb),
        .err_any   (err_reg),
        .clear_err (clear_err),
        .clr_flags (clr_flags)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            eclr_bit_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .cap_stb  (cap_stb),
                .chk_stb  (chk_stb),
                .clr_flag (clr_flags),
                .d_bit    (d[i]),
                .main_bit (f_vec[i]),
                .flag_bit (flag_vec[i]),
                .q_bit    (q[i])
            );
        end
    endgenerate

    // Register error: OR of all bit flags.
    always_comb err_reg = |flag_vec;

endmodule

// File: rtl/eclr_register_chk.sv
// Module: eclr_register_chk
// Assertion checker bound into eclr_register. It watches ports plus the
// check strobe and captured word. Assumes synchronous active-low reset.
module eclr_register_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cap_stb,
    input logic         chk_stb,
    input logic         mode_deep,
    input logic         clear_err,
    input logic [N-1:0] d,
    input logic [N-1:0] f_vec,
    input logic [N-1:0] q,
    input logic         err_reg
);

    // R1: reset empties outputs.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0) && !err_reg);

    // R3 / R5: a check without a capture reports any mismatch.
    a_r3_check_flags_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        chk_stb && !cap_stb |=> err_reg == ($past(d) != $past(f_vec)));

    // R6: shallow capture releases flags.
    a_r6_shallow_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_deep && cap_stb && !chk_stb |=> !err_reg);

    // R7: deep mode keeps flags without a clear.
    a_r7_deep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mode_deep && !clear_err && !chk_stb && err_reg |=> err_reg);

    // R7: deep clear releases flags.
    a_r7_deep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_deep && clear_err && !chk_stb |=> !err_reg);

    // R9: quiet edges leave the output alone.
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb && !chk_stb && !(mode_deep && clear_err) |=> $stable(q) && $stable(err_reg));

endmodule

bind eclr_register eclr_register_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_stb   (cap_stb),
    .chk_stb   (chk_stb),
    .mode_deep (mode_deep),
    .clear_err (clear_err),
    .d         (d),
    .f_vec     (f_vec),
    .q         (q),
    .err_reg   (err_reg)
);

// File: tb/eclr_register_test.sv
// Directed bench for eclr_register: one task per scenario, each self-checking.
module eclr_register_test;

    localparam int N   = 8;
    localparam int DLY = 2;

    logic         clk       = 1'b0;
    logic         rst_n     = 1'b0;
    logic         cap_stb   = 1'b0;
    logic         mode_deep = 1'b0;
    logic         clear_err = 1'b0;
    logic [N-1:0] d         = '0;
    logic [N-1:0] q;
    logic         err_reg;

    int n_checks = 0;
    int n_fails  = 0;

    eclr_register #(.N(N), .CHECK_DELAY(DLY)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb   (cap_stb),
        .mode_deep (mode_deep),
        .clear_err (clear_err),
        .d         (d),
        .q         (q),
        .err_reg   (err_reg)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [N-1:0] act_q, input logic [N-1:0] exp_q,
                         input logic act_e, input logic exp_e);
        n_checks++;
        if (act_q !== exp_q || act_e !== exp_e) begin
            n_fails++;
            $display("FAIL %s: q=%h err=%b expected q=%h err=%b", tag, act_q, act_e, exp_q, exp_e);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Capture word c^e, then present c late; stop right after the check edge.
    task automatic late_capture(input logic [N-1:0] c, input logic [N-1:0] e);
        d = c ^ e; cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0; d = c;
        repeat (DLY) @(negedge clk);
    endtask

    task automatic t_reset();
        d = '1; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state", q, '0, err_reg, 1'b0);
    endtask

    task automatic t_clean();
        d = 8'h3C; cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0;
        check("R2 captured word", q, 8'h3C, err_reg, 1'b0);
        repeat (DLY) @(negedge clk);
        check("R2 no error after check", q, 8'h3C, err_reg, 1'b0);
    endtask

    task automatic t_single();
        d = 8'hA5 ^ 8'h01; cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0; d = 8'hA5;
        repeat (DLY - 1) @(negedge clk);
        check("R3 before check edge", q, 8'hA4, err_reg, 1'b0);
        @(negedge clk);
        check("R3 R5 single bit corrected", q, 8'hA5, err_reg, 1'b1);
    endtask

    task automatic t_multi();
        cap_stb = 1'b1; d = 8'h11;
        @(negedge clk);
        cap_stb = 1'b0;
        repeat (DLY) @(negedge clk);
        late_capture(8'h5A, 8'h81);
        check("R4 two bits corrected, others kept", q, 8'h5A, err_reg, 1'b1);
    endtask

    task automatic t_quiet();
        d = 8'hFF;
        @(negedge clk);
        d = 8'h00;
        @(negedge clk);
        check("R9 d change ignored", q, 8'h5A, err_reg, 1'b1);
    endtask

    task automatic t_shallow();
        mode_deep = 1'b0; clear_err = 1'b1;
        @(negedge clk);
        clear_err = 1'b0;
        check("R6 clear_err ignored in shallow", q, 8'h5A, err_reg, 1'b1);
        d = 8'h77; cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0;
        check("R6 capture clears flags", q, 8'h77, err_reg, 1'b0);
        repeat (DLY) @(negedge clk);
        check("R6 clean after check", q, 8'h77, err_reg, 1'b0);
    endtask

    task automatic t_deep();
        mode_deep = 1'b1;
        @(negedge clk);
        late_capture(8'hC3, 8'h10);
        check("R7 deep error flagged", q, 8'hC3, err_reg, 1'b1);
        d = 8'h0F; cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0; clear_err = 1'b1;
        check("R7 capture keeps flag", q, 8'h1F, err_reg, 1'b1);
        @(negedge clk);
        clear_err = 1'b0;
        check("R7 clear_err releases", q, 8'h0F, err_reg, 1'b0);
        @(negedge clk);
        check("R7 check after clear", q, 8'h0F, err_reg, 1'b0);
    endtask

    task automatic t_coincide();
        late_capture(8'h96, 8'h02);
        check("R8 setup flag", q, 8'h96, err_reg, 1'b1);
        d = 8'h96 ^ 8'h40; cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0; d = 8'h96;
        repeat (DLY - 1) @(negedge clk);
        clear_err = 1'b1;
        @(negedge clk);
        clear_err = 1'b0;
        check("R8 check wins over clear", q, 8'h96, err_reg, 1'b1);
        clear_err = 1'b1;
        @(negedge clk);
        clear_err = 1'b0;
        check("R7 final clear", q, 8'hD6, err_reg, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_clean();
        t_single();
        t_multi();
        t_quiet();
        t_shallow();
        t_deep();
        t_coincide();
        summary();
    end

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, expected completion");
        summary();
    end

endmodule